// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a fast reference clock into the sixteen-times-oversampling enable that a UART shifter consumes. The enable is a one-cycle pulse. The spacing between pulses is set by a 14-bit whole divisor plus a 3-bit fraction counted in eighths of a reference cycle. With a 48 MHz reference and a divisor D, the pulse rate is 48 MHz / D and the line rate is 3 MHz / D.

The fraction works through a small phase accumulator. At each period boundary the accumulator adds the fraction. When the add carries out, the period that begins at that boundary lasts one extra reference cycle. Over eight periods this gives exactly D + f/8 on average.

Two whole-divisor codes are reserved for the top speeds, and the fraction is ignored for both. Code 0 runs the enable on every reference cycle, which gives 3 Mbaud. Code 1 alternates one-cycle and two-cycle periods, which averages 1.5 cycles and gives 2 Mbaud. The inputs are sampled only at a period boundary. A new setting therefore never cuts short the period in progress, and a changed setting restarts the fraction pattern from zero.

Top module: `baud_frac_gen`

## Requirements
- R1: While reset is low the tick output stays low. After reset is released with whole divisor N ≥ 2, the first tick comes on the N-th clock cycle.
- R2: For a whole divisor N ≥ 2, every gap between consecutive ticks is N or N+1 reference cycles.
- R3: When the effective setting changes, the accumulator restarts from zero. Period k (k = 1..8) after the change is N + (floor(k·f/8) − floor((k−1)·f/8)), where f is the 3-bit fraction code (value f means f/8).
- R4: With fraction code 0, every period is exactly N cycles and no period is stretched.
- R5: Whole divisor code 0 makes the tick high on every cycle, whatever the fraction code.
- R6: Whole divisor code 1 gives periods of 1, 2, 1, 2, … cycles, starting with 1 after a change, whatever the fraction code.
- R7: Changing only the fraction while the whole divisor is 0 or 1 is not a change of setting. The 1/2 alternation continues without restarting.
- R8: The inputs are sampled only at a tick. A period already in progress completes at its old length, and the new length applies from the next period.
- R9: The largest whole divisor, 16383, gives a period of 16383 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_int | input | 14 | Whole part of the divisor (0 and 1 are the reserved top-speed codes) |
| div_frac | input | 3 | Fraction of the divisor in eighths |
| tick16 | output | 1 | One-cycle enable at sixteen times the baud rate |

## Verification
A vector table sweeps divisors with fractions 0, 1, 2, 3, 4, 5 and 7. Each is checked period by period against an independent model. This separates a wrong stretch position from a wrong total, and it separates a missing restart of the accumulator from a correct one. The reserved codes 0 and 1 are tried with several fraction codes to show that the fraction has no effect on them. A fraction-only change in the middle of the code-1 alternation shows that no restart happens there. A change made partway through a long period shows that the old period finishes intact. The largest divisor and the first tick after reset are checked as boundary cases.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

  // Rate class of the applied setting
  typedef enum logic [1:0] {
    RATE_FULL   = 2'd0,  // tick every reference cycle
    RATE_THREE2 = 2'd1,  // alternate 1 and 2 cycle periods
    RATE_DIV    = 2'd2   // ordinary whole-plus-eighths divisor
  } rate_kind_e;

endpackage

// File: rtl/baud_cfg_sel.sv
module baud_cfg_sel #(
  parameter int INT_W  = 14,
  parameter int FRAC_W = 3
) (
  input  logic [INT_W-1:0]        div_int,
  input  logic [FRAC_W-1:0]       div_frac,
  output logic [INT_W-1:0]        eff_int,
  output logic [FRAC_W-1:0]       eff_frac,
  output baudgen_pkg::rate_kind_e kind
);
  import baudgen_pkg::*;

  localparam logic [FRAC_W-1:0] HALF_STEP = FRAC_W'(1) << (FRAC_W - 1);
  localparam logic [INT_W-1:0]  ONE_INT   = INT_W'(1);

  function automatic rate_kind_e classify(input logic [INT_W-1:0] d);
    if (d == '0)          return RATE_FULL;
    else if (d == ONE_INT) return RATE_THREE2;
    else                  return RATE_DIV;
  endfunction

  always_comb begin
    kind = classify(div_int);
    unique case (kind)
      RATE_FULL: begin
        eff_int  = ONE_INT;
        eff_frac = '0;
      end
      RATE_THREE2: begin
        eff_int  = ONE_INT;
        eff_frac = HALF_STEP;
      end
      default: begin
        eff_int  = div_int;
        eff_frac = div_frac;
      end
    endcase
  end
endmodule

// File: rtl/baud_frac_acc.sv
module baud_frac_acc #(
  parameter int FRAC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              restart,
  input  logic [FRAC_W-1:0] frac,
  output logic              carry
);
  logic [FRAC_W-1:0] phase_q;
  logic [FRAC_W:0]   phase_sum;

  function automatic logic [FRAC_W:0] phase_add(input logic [FRAC_W-1:0] base,
                                                input logic [FRAC_W-1:0] inc);
    return {1'b0, base} + {1'b0, inc};
  endfunction

  assign phase_sum = phase_add(restart ? '0 : phase_q, frac);
  assign carry     = phase_sum[FRAC_W];

  always_ff @(posedge clk) begin
    if (!rst_n)    phase_q <= '0;
    else if (step) phase_q <= phase_sum[FRAC_W-1:0];
  end
endmodule

// File: rtl/baud_period_cnt.sv
module baud_period_cnt #(
  parameter int INT_W = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [INT_W:0] len,
  output logic           at_zero
);
  logic [INT_W-1:0] remain_q;

  function automatic logic [INT_W-1:0] first_count(input logic [INT_W:0] l);
    return INT_W'(l - 1'b1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)                remain_q <= '0;
    else if (load)             remain_q <= first_count(len);
    else if (remain_q != '0)   remain_q <= remain_q - 1'b1;
  end

  assign at_zero = (remain_q == '0);
endmodule

// File: rtl/baud_frac_gen.sv
module baud_frac_gen #(
  parameter int INT_W  = 14,
  parameter int FRAC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick16
);
  import baudgen_pkg::*;

  localparam int LEN_W = INT_W + 1;

  logic              running_q;
  logic [INT_W-1:0]  act_int_q;
  logic [FRAC_W-1:0] act_frac_q;

  logic [INT_W-1:0]  eff_int;
  logic [FRAC_W-1:0] eff_frac;
  rate_kind_e        kind;

  // Named internal events for the checker
  logic              cnt_zero;
  logic              boundary;
  logic              cfg_change;
  logic              stretch;
  logic [LEN_W-1:0]  period_len;

  baud_cfg_sel #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_sel (
    .div_int  (div_int),
    .div_frac (div_frac),
    .eff_int  (eff_int),
    .eff_frac (eff_frac),
    .kind     (kind)
  );

  assign boundary   = !running_q || cnt_zero;
  assign cfg_change = !running_q || (eff_int != act_int_q) || (eff_frac != act_frac_q);

  baud_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (boundary),
    .restart (cfg_change),
    .frac    (eff_frac),
    .carry   (stretch)
  );

  assign period_len = {1'b0, eff_int} + LEN_W'(stretch);

  baud_period_cnt #(.INT_W(INT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (boundary),
    .len     (period_len),
    .at_zero (cnt_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running_q  <= 1'b0;
      act_int_q  <= '0;
      act_frac_q <= '0;
    end else begin
      running_q <= 1'b1;
      if (boundary) begin
        act_int_q  <= eff_int;
        act_frac_q <= eff_frac;
      end
    end
  end

  assign tick16 = running_q && cnt_zero;
endmodule

// File: rtl/baud_frac_gen_chk.sv
module baud_frac_gen_chk #(
  parameter int INT_W  = 14,
  parameter int FRAC_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [INT_W-1:0]  div_int,
  input logic              tick16,
  input logic              boundary,
  input logic              stretch,
  input logic [INT_W:0]    period_len,
  input logic [FRAC_W-1:0] act_frac_q
);
  logic [INT_W:0] gap_q;
  logic [INT_W:0] want_q;
  logic           have_want_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q       <= '0;
      want_q      <= '0;
      have_want_q <= 1'b0;
    end else if (boundary) begin
      gap_q       <= (INT_W+1)'(1);
      want_q      <= period_len;
      have_want_q <= 1'b1;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R2: the measured gap equals the length chosen at the previous boundary
  p_gap_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick16 && have_want_q) |-> (gap_q == want_q));

  // R4: a stretched period needs a nonzero applied fraction
  p_stretch_frac_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && stretch) |-> (act_frac_q != '0));

  // R5: code 0 keeps the tick high on the following cycle
  p_full_rate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick16 && div_int == '0) |=> tick16);

  // R6: under code 1 a one-cycle period is followed by a two-cycle period
  p_alternate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick16 && $past(tick16) && $past(div_int) == INT_W'(1) && div_int == INT_W'(1)) |=> !tick16);
endmodule

bind baud_frac_gen baud_frac_gen_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .div_int    (div_int),
  .tick16     (tick16),
  .boundary   (boundary),
  .stretch    (stretch),
  .period_len (period_len),
  .act_frac_q (act_frac_q)
);

// File: tb/tb_baud_frac_gen.sv
`timescale 1ns/1ps
module tb_baud_frac_gen;
  localparam int INT_W  = 14;
  localparam int FRAC_W = 3;
  localparam int NV     = 12;
  localparam int LIMIT  = 200000;

  // whole divisor, fraction code
  localparam int VEC [NV][2] = '{
    '{2, 0}, '{2, 1}, '{3, 5}, '{7, 7}, '{12, 3}, '{5, 4},
    '{100, 2}, '{300, 7}, '{0, 0}, '{0, 6}, '{1, 0}, '{1, 3}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [INT_W-1:0]  div_int = '0;
  logic [FRAC_W-1:0] div_frac = '0;
  logic              tick16;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  baud_frac_gen #(.INT_W(INT_W), .FRAC_W(FRAC_W)) dut (
    .clk(clk), .rst_n(rst_n), .div_int(div_int), .div_frac(div_frac), .tick16(tick16)
  );

  // Period k after a change, derived from the requirements
  function automatic int model_len(input int n, input int f, input int k);
    if (n == 0) return 1;
    if (n == 1) return (k % 2 == 1) ? 1 : 2;
    return n + ((k * f) / 8 - ((k - 1) * f) / 8);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a negedge where tick16 was seen; returns cycles to the next tick
  task automatic next_gap(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick16 && n < LIMIT);
  endtask

  // Set inputs at a negedge, then wait for the tick whose boundary samples them
  task automatic apply(input int n, input int f);
    div_int  = INT_W'(n);
    div_frac = FRAC_W'(f);
    while (!tick16) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=0", LIMIT);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    int gap;
    int sum;
    int lat;
    // R1: quiet while in reset
    div_int = INT_W'(5);
    repeat (4) begin
      @(negedge clk);
      check("R1 reset low", int'(tick16), 0);
    end
    rst_n = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!tick16 && lat < 100);
    check("R1 first tick latency", lat, 5);

    // Table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][0], VEC[v][1]);
      sum = 0;
      for (int k = 1; k <= 8; k++) begin
        next_gap(gap);
        sum += gap;
        check($sformatf("R3 n=%0d f=%0d period %0d", VEC[v][0], VEC[v][1], k),
              gap, model_len(VEC[v][0], VEC[v][1], k));
      end
      if (VEC[v][0] >= 2)
        check($sformatf("R2 n=%0d f=%0d eight-period sum", VEC[v][0], VEC[v][1]),
              sum, 8 * VEC[v][0] + VEC[v][1]);
      else if (VEC[v][0] == 0)
        check($sformatf("R5 f=%0d eight-period sum", VEC[v][1]), sum, 8);
      else
        check($sformatf("R6 f=%0d eight-period sum", VEC[v][1]), sum, 12);
    end

    // R4: fraction 0 gives exactly N each time
    apply(9, 0);
    for (int k = 0; k < 4; k++) begin
      next_gap(gap);
      check("R4 no stretch", gap, 9);
    end

    // R7: a fraction-only change under code 1 does not restart the alternation
    apply(1, 0);
    next_gap(gap);
    check("R7 first period under code 1", gap, 1);
    div_frac = FRAC_W'(7);
    next_gap(gap);
    check("R7 alternation continues", gap, 2);
    next_gap(gap);
    check("R7 alternation continues", gap, 1);

    // R8: a change in mid-period lets the old period finish
    apply(10, 0);
    next_gap(gap);
    check("R8 settle", gap, 10);
    repeat (3) @(negedge clk);
    div_int = INT_W'(4);
    gap = 3;
    do begin
      @(negedge clk);
      gap++;
    end while (!tick16 && gap < 100);
    check("R8 old period intact", gap, 10);
    next_gap(gap);
    check("R8 new length applied", gap, 4);

    // R9: the largest divisor
    apply(16383, 7);
    next_gap(gap);
    check("R9 max divisor", gap, 16383);

    // R1: reset mid-run forces the tick low
    apply(0, 0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", int'(tick16), 0);
    @(negedge clk);
    check("R1 reset mid-run", int'(tick16), 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule